// File: doc/BRIEF.md
# Compressed DFA Next-State Lookup Engine

This block computes one transition of a regular-expression automaton whose transition function is stored in compressed form. Each cycle it accepts a current state ID, the class of the input byte and the number of the automaton it belongs to. Three registered stages later it returns the next state ID, together with a flag that marks that state as accepting.

The transitions are kept in three tiers. A 2-bit code per (state, class) pair names one of three frequent successors, which are held in a per-state row of three state IDs. A state whose remaining transitions are few keeps them in K parallel tagged banks. All K banks are read at the state's row and matched against the input class. Any other state keeps its remaining transitions in a dense row with one entry per class. A per-automaton threshold on the state ID picks between the banked tier and the dense tier.

Up to four automata share every table. Each one has its own base offset into each table, its own threshold and its own default state. All tables and settings are loaded through one write port. A lookup has no feedback inside the block, so independent flows can be interleaved, and the caller returns each result as the next current state three cycles later.

Top module: `dfa_step_engine`

## Requirements
- R1: Every cycle with `in_valid` high yields exactly one result with `out_valid` high three clock edges later, in issue order; back-to-back lookups are accepted every cycle, and `out_valid` is low three edges after a cycle without `in_valid`.
- R2: The code for class c is bits [2c+1:2c] of the code row at (code base + state). Codes 0, 1 and 2 return bits [7:0], [15:8] and [23:16] respectively of the successor row at (successor base + state).
- R3: With code 3 and a state below the automaton's threshold, the next state is the 8-bit ID of the bank entry at (bank base + state) that is valid and whose 4-bit tag equals the input class. A bank entry is {valid[12], tag[11:8], next[7:0]}.
- R4: With code 3, a state below the threshold and no valid entry whose tag matches, the next state is the automaton's default state; an entry whose valid bit is clear never matches, whatever its tag.
- R5: When several valid bank entries carry the matching tag, the entry in the lowest-numbered bank wins.
- R6: With code 3 and a state at or above the threshold, the next state is the dense entry at index (dense row base + state - threshold) * 16 + class, where the row term wraps at 6 bits.
- R7: Each automaton's base offsets are added, modulo 256, to the row index of the code, successor, bank and accept tables, so the same state and class in two automata can resolve differently.
- R8: `out_accept` is the accept-map bit at (accept base + next state) of the automaton that issued the lookup.
- R9: During and right after reset, `out_valid`, `out_state` and `out_accept` are 0, and every per-automaton setting is 0.
- R10: In cycles with `out_valid` low, `out_state` and `out_accept` keep the values of the last result.
- R11: Writes use `wr_sel` 0 for code rows (addr = row, 32-bit data), 1 for successor rows (addr = row, data[23:0]), 2 for bank entries (addr[9:8] = bank, addr[7:0] = row, data[12:0]), 3 for dense entries (addr = row*16+class, data[7:0]), 4 for accept bits (addr = ID, data[0]) and 5 for settings (addr[1:0] = automaton, addr[4:2] = field, data[7:0]). The setting fields are 0 code base, 1 successor base, 2 bank base, 3 dense row base (6 bits), 4 accept base, 5 threshold and 6 default state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A lookup is presented this cycle |
| in_dfa | input | 2 | Automaton number of the lookup |
| in_state | input | 8 | Current state ID |
| in_class | input | 4 | Character class of the input byte |
| wr_en | input | 1 | Table or setting write strobe |
| wr_sel | input | 3 | Write target (see R11) |
| wr_addr | input | 10 | Write address |
| wr_data | input | 32 | Write data |
| out_valid | output | 1 | A result is present |
| out_state | output | 8 | Next state ID |
| out_accept | output | 1 | Next state is accepting |

## Verification
The bench builds the engine with its default parameters: 8-bit state IDs, 16 classes, four banks and four automata. With four banks it can fill a bank row completely. One row holds a duplicated tag in banks 1 and 3 and an invalid entry carrying a live tag, which makes the priority and valid-bit rules observable. A threshold of 16 lets states 15 and 16 probe both sides of the tier boundary. A second automaton with nonzero bases in every table shows that identical state and class inputs land in distinct rows.

// File: rtl/dfa_step_pkg.sv
package dfa_step_pkg;

    localparam int STATE_W     = 8;
    localparam int CLASS_W     = 4;
    localparam int NUM_CLASS   = 1 << CLASS_W;
    localparam int SPARSE_K    = 4;
    localparam int DFA_W       = 2;
    localparam int NUM_DFA     = 1 << DFA_W;
    localparam int DENSE_ROW_W = 6;
    localparam int DENSE_IDX_W = DENSE_ROW_W + CLASS_W;
    localparam int NUM_ROWS    = 1 << STATE_W;
    localparam int CODE_W      = 2;
    localparam int CODE_ROW_W  = CODE_W * NUM_CLASS;
    localparam int TOP_N       = 3;
    localparam int TOP_ROW_W   = TOP_N * STATE_W;
    localparam int WR_ADDR_W   = 10;
    localparam int WR_DATA_W   = 32;
    localparam int CFG_FIELD_W = 3;
    localparam int CFG_ADDR_W  = DFA_W + CFG_FIELD_W;

    localparam logic [CODE_W-1:0] CODE_FALLBACK = 2'b11;

    typedef enum logic [2:0] {
        TBL_CODE   = 3'd0,
        TBL_TOP    = 3'd1,
        TBL_SPARSE = 3'd2,
        TBL_DENSE  = 3'd3,
        TBL_ACCEPT = 3'd4,
        TBL_CFG    = 3'd5
    } tbl_sel_e;

    localparam logic [CFG_FIELD_W-1:0] FLD_CODE_BASE   = 3'd0;
    localparam logic [CFG_FIELD_W-1:0] FLD_TOP_BASE    = 3'd1;
    localparam logic [CFG_FIELD_W-1:0] FLD_SPARSE_BASE = 3'd2;
    localparam logic [CFG_FIELD_W-1:0] FLD_DENSE_BASE  = 3'd3;
    localparam logic [CFG_FIELD_W-1:0] FLD_ACC_BASE    = 3'd4;
    localparam logic [CFG_FIELD_W-1:0] FLD_THRESHOLD   = 3'd5;
    localparam logic [CFG_FIELD_W-1:0] FLD_DEFAULT     = 3'd6;

    typedef struct packed {
        logic               vld;
        logic [CLASS_W-1:0] tag;
        logic [STATE_W-1:0] nxt;
    } sparse_ent_t;

    localparam int SPARSE_ENT_W = $bits(sparse_ent_t);

    typedef struct packed {
        logic [STATE_W-1:0]     code_base;
        logic [STATE_W-1:0]     top_base;
        logic [STATE_W-1:0]     sparse_base;
        logic [DENSE_ROW_W-1:0] dense_base;
        logic [STATE_W-1:0]     acc_base;
        logic [STATE_W-1:0]     threshold;
        logic [STATE_W-1:0]     dflt;
    } dfa_cfg_t;

endpackage

// File: rtl/dfa_cfg_bank.sv
module dfa_cfg_bank
    import dfa_step_pkg::*;
#(
    parameter int N_DFA = NUM_DFA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [CFG_ADDR_W-1:0] wr_addr,
    input  logic [STATE_W-1:0]    wr_data,
    input  logic [DFA_W-1:0]      rd_dfa,
    output dfa_cfg_t              rd_cfg
);

    dfa_cfg_t cfg_d [N_DFA];
    dfa_cfg_t cfg_q [N_DFA];

    logic [DFA_W-1:0]       sel_dfa;
    logic [CFG_FIELD_W-1:0] sel_fld;

    assign sel_dfa = wr_addr[DFA_W-1:0];
    assign sel_fld = wr_addr[DFA_W +: CFG_FIELD_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (wr_sel == TBL_CFG)) begin
            case (sel_fld)
                FLD_CODE_BASE:   cfg_d[sel_dfa].code_base   = wr_data;
                FLD_TOP_BASE:    cfg_d[sel_dfa].top_base    = wr_data;
                FLD_SPARSE_BASE: cfg_d[sel_dfa].sparse_base = wr_data;
                FLD_DENSE_BASE:  cfg_d[sel_dfa].dense_base  = wr_data[DENSE_ROW_W-1:0];
                FLD_ACC_BASE:    cfg_d[sel_dfa].acc_base    = wr_data;
                FLD_THRESHOLD:   cfg_d[sel_dfa].threshold   = wr_data;
                FLD_DEFAULT:     cfg_d[sel_dfa].dflt        = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_DFA; i++) begin
                cfg_q[i] <= '0;
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_cfg = cfg_q[rd_dfa];

endmodule

// File: rtl/dfa_tables.sv
module dfa_tables
    import dfa_step_pkg::*;
#(
    parameter int K = SPARSE_K
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [WR_ADDR_W-1:0]    wr_addr,
    input  logic [WR_DATA_W-1:0]    wr_data,
    input  logic [STATE_W-1:0]      rd_code_idx,
    input  logic [STATE_W-1:0]      rd_top_idx,
    input  logic [STATE_W-1:0]      rd_sparse_idx,
    input  logic [DENSE_IDX_W-1:0]  rd_dense_idx,
    input  logic [STATE_W-1:0]      rd_acc_idx,
    output logic [CODE_ROW_W-1:0]   code_row,
    output logic [TOP_ROW_W-1:0]    top_row,
    output sparse_ent_t [K-1:0]     sparse_row,
    output logic [STATE_W-1:0]      dense_nxt,
    output logic                    acc_bit
);

    localparam int BANK_W      = (K > 1) ? $clog2(K) : 1;
    localparam int DENSE_DEPTH = 1 << DENSE_IDX_W;

    logic [CODE_ROW_W-1:0] code_mem  [NUM_ROWS];
    logic [TOP_ROW_W-1:0]  top_mem   [NUM_ROWS];
    logic [STATE_W-1:0]    dense_mem [DENSE_DEPTH];
    logic                  acc_mem   [NUM_ROWS];

    logic [STATE_W-1:0] row_addr;
    assign row_addr = wr_addr[STATE_W-1:0];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            case (wr_sel)
                TBL_CODE:   code_mem[row_addr]                   <= wr_data[CODE_ROW_W-1:0];
                TBL_TOP:    top_mem[row_addr]                    <= wr_data[TOP_ROW_W-1:0];
                TBL_DENSE:  dense_mem[wr_addr[DENSE_IDX_W-1:0]]  <= wr_data[STATE_W-1:0];
                TBL_ACCEPT: acc_mem[row_addr]                    <= wr_data[0];
                default: ;
            endcase
        end
    end

    for (genvar b = 0; b < K; b++) begin : g_bank
        sparse_ent_t bank_mem [NUM_ROWS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == TBL_SPARSE) &&
                (wr_addr[STATE_W +: BANK_W] == BANK_W'(b))) begin
                bank_mem[row_addr] <= sparse_ent_t'(wr_data[SPARSE_ENT_W-1:0]);
            end
        end

        assign sparse_row[b] = bank_mem[rd_sparse_idx];
    end

    assign code_row  = code_mem[rd_code_idx];
    assign top_row   = top_mem[rd_top_idx];
    assign dense_nxt = dense_mem[rd_dense_idx];
    assign acc_bit   = acc_mem[rd_acc_idx];

endmodule

// File: rtl/dfa_sparse_pick.sv
module dfa_sparse_pick
    import dfa_step_pkg::*;
#(
    parameter int K = SPARSE_K
) (
    input  sparse_ent_t [K-1:0] row,
    input  logic [CLASS_W-1:0]  cls,
    input  logic [STATE_W-1:0]  dflt,
    output logic [STATE_W-1:0]  nxt,
    output logic                hit
);

    logic [K-1:0] match;

    for (genvar b = 0; b < K; b++) begin : g_match
        assign match[b] = row[b].vld && (row[b].tag == cls);
    end

    // Scan from the highest bank down so the lowest matching bank is kept.
    always_comb begin
        nxt = dflt;
        hit = 1'b0;
        for (int b = K - 1; b >= 0; b--) begin
            if (match[b]) begin
                nxt = row[b].nxt;
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dfa_step_engine.sv
module dfa_step_engine
    import dfa_step_pkg::*;
#(
    parameter int K = SPARSE_K
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DFA_W-1:0]     in_dfa,
    input  logic [STATE_W-1:0]   in_state,
    input  logic [CLASS_W-1:0]   in_class,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [WR_ADDR_W-1:0] wr_addr,
    input  logic [WR_DATA_W-1:0] wr_data,
    output logic                 out_valid,
    output logic [STATE_W-1:0]   out_state,
    output logic                 out_accept
);

    typedef struct packed {
        logic                   vld;
        logic [CLASS_W-1:0]     cls;
        logic [STATE_W-1:0]     code_idx;
        logic [STATE_W-1:0]     top_idx;
        logic [STATE_W-1:0]     sparse_idx;
        logic [DENSE_IDX_W-1:0] dense_idx;
        logic                   use_sparse;
        logic [STATE_W-1:0]     dflt;
        logic [STATE_W-1:0]     acc_base;
    } addr_stage_t;

    typedef struct packed {
        logic                   vld;
        logic [CODE_W-1:0]      code;
        logic [TOP_ROW_W-1:0]   top_row;
        sparse_ent_t [K-1:0]    sp_row;
        logic [STATE_W-1:0]     dense_nxt;
        logic [CLASS_W-1:0]     cls;
        logic                   use_sparse;
        logic [STATE_W-1:0]     dflt;
        logic [STATE_W-1:0]     acc_base;
    } read_stage_t;

    typedef struct packed {
        logic               vld;
        logic [STATE_W-1:0] state;
        logic               accept;
    } out_stage_t;

    typedef struct packed {
        addr_stage_t s1;
        read_stage_t s2;
        out_stage_t  s3;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    dfa_cfg_t               cfg;
    logic [CODE_ROW_W-1:0]  tbl_code_row;
    logic [TOP_ROW_W-1:0]   tbl_top_row;
    sparse_ent_t [K-1:0]    tbl_sparse_row;
    logic [STATE_W-1:0]     tbl_dense_nxt;
    logic                   tbl_acc_bit;
    logic [STATE_W-1:0]     pick_nxt;
    logic                   pick_hit;
    logic [STATE_W-1:0]     top_pick;
    logic [STATE_W-1:0]     next_st;
    logic [STATE_W-1:0]     acc_idx;
    logic [STATE_W-1:0]     dense_off;
    logic [DENSE_ROW_W-1:0] dense_row;

    dfa_cfg_bank #(
        .N_DFA (NUM_DFA)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr[CFG_ADDR_W-1:0]),
        .wr_data (wr_data[STATE_W-1:0]),
        .rd_dfa  (in_dfa),
        .rd_cfg  (cfg)
    );

    dfa_tables #(
        .K (K)
    ) i_tables (
        .clk           (clk),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_code_idx   (pipe_q.s1.code_idx),
        .rd_top_idx    (pipe_q.s1.top_idx),
        .rd_sparse_idx (pipe_q.s1.sparse_idx),
        .rd_dense_idx  (pipe_q.s1.dense_idx),
        .rd_acc_idx    (acc_idx),
        .code_row      (tbl_code_row),
        .top_row       (tbl_top_row),
        .sparse_row    (tbl_sparse_row),
        .dense_nxt     (tbl_dense_nxt),
        .acc_bit       (tbl_acc_bit)
    );

    dfa_sparse_pick #(
        .K (K)
    ) i_pick (
        .row  (pipe_q.s2.sp_row),
        .cls  (pipe_q.s2.cls),
        .dflt (pipe_q.s2.dflt),
        .nxt  (pick_nxt),
        .hit  (pick_hit)
    );

    // Resolve stage: path choice and accept-map index.
    always_comb begin
        top_pick = pipe_q.s2.top_row[pipe_q.s2.code * STATE_W +: STATE_W];
        if (pipe_q.s2.code != CODE_FALLBACK) begin
            next_st = top_pick;
        end else if (pipe_q.s2.use_sparse) begin
            next_st = pick_nxt;
        end else begin
            next_st = pipe_q.s2.dense_nxt;
        end
        acc_idx = pipe_q.s2.acc_base + next_st;
    end

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: form table indices from the per-automaton bases.
        dense_off = in_state - cfg.threshold;
        dense_row = cfg.dense_base + dense_off[DENSE_ROW_W-1:0];
        pipe_d.s1.vld = in_valid;
        if (in_valid) begin
            pipe_d.s1.cls        = in_class;
            pipe_d.s1.code_idx   = cfg.code_base + in_state;
            pipe_d.s1.top_idx    = cfg.top_base + in_state;
            pipe_d.s1.sparse_idx = cfg.sparse_base + in_state;
            pipe_d.s1.dense_idx  = {dense_row, in_class};
            pipe_d.s1.use_sparse = in_state < cfg.threshold;
            pipe_d.s1.dflt       = cfg.dflt;
            pipe_d.s1.acc_base   = cfg.acc_base;
        end

        // Stage 2: capture every table read in parallel.
        pipe_d.s2.vld = pipe_q.s1.vld;
        if (pipe_q.s1.vld) begin
            pipe_d.s2.code       = tbl_code_row[pipe_q.s1.cls * CODE_W +: CODE_W];
            pipe_d.s2.top_row    = tbl_top_row;
            pipe_d.s2.sp_row     = tbl_sparse_row;
            pipe_d.s2.dense_nxt  = tbl_dense_nxt;
            pipe_d.s2.cls        = pipe_q.s1.cls;
            pipe_d.s2.use_sparse = pipe_q.s1.use_sparse;
            pipe_d.s2.dflt       = pipe_q.s1.dflt;
            pipe_d.s2.acc_base   = pipe_q.s1.acc_base;
        end

        // Stage 3: register the resolved state; hold it when idle.
        pipe_d.s3.vld = pipe_q.s2.vld;
        if (pipe_q.s2.vld) begin
            pipe_d.s3.state  = next_st;
            pipe_d.s3.accept = tbl_acc_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid  = pipe_q.s3.vld;
    assign out_state  = pipe_q.s3.state;
    assign out_accept = pipe_q.s3.accept;

endmodule

// File: rtl/dfa_step_chk.sv
module dfa_step_chk
    import dfa_step_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [STATE_W-1:0] out_state,
    input logic               out_accept,
    input logic               s2_vld,
    input logic [CODE_W-1:0]  s2_code,
    input logic               s2_sparse,
    input logic               pick_hit,
    input logic [STATE_W-1:0] s2_dflt,
    input logic [STATE_W-1:0] top_pick
);

    // R1: a lookup yields a result three edges later
    a_r1_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R1: no result without a lookup three edges earlier
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R2: a frequent-successor code lands the chosen field on the output
    a_r2_top_field: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && (s2_code != CODE_FALLBACK)) |=> (out_state == $past(top_pick)));

    // R4: a bank miss produces the automaton's default state
    a_r4_default_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && (s2_code == CODE_FALLBACK) && s2_sparse && !pick_hit)
            |=> (out_state == $past(s2_dflt)));

    // R10: outputs hold while no result is present
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_state) && $stable(out_accept)));

endmodule

bind dfa_step_engine dfa_step_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_state  (out_state),
    .out_accept (out_accept),
    .s2_vld     (pipe_q.s2.vld),
    .s2_code    (pipe_q.s2.code),
    .s2_sparse  (pipe_q.s2.use_sparse),
    .pick_hit   (pick_hit),
    .s2_dflt    (pipe_q.s2.dflt),
    .top_pick   (top_pick)
);

// File: tb/test_dfa_step_engine.sv
module test_dfa_step_engine;

    localparam logic [2:0] W_CODE = 3'd0, W_TOP = 3'd1, W_BANK = 3'd2,
                           W_DENSE = 3'd3, W_ACC = 3'd4, W_CFG = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_dfa = '0;
    logic [7:0]  in_state = '0;
    logic [3:0]  in_class = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        out_valid;
    logic [7:0]  out_state;
    logic        out_accept;

    always #4 clk = ~clk;

    dfa_step_engine i_dfa_step_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dfa(in_dfa),
        .in_state(in_state), .in_class(in_class), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid),
        .out_state(out_state), .out_accept(out_accept)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit started = 1'b0;
    bit have_last = 1'b0;
    logic [7:0] last_st = '0;
    logic       last_acc = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model of the stored contents, kept from the writes.
    logic [31:0] m_code  [256];
    logic [23:0] m_top   [256];
    logic [12:0] m_bank  [4][256];
    logic [7:0]  m_dense [1024];
    logic        m_acc   [256];
    logic [7:0]  m_cb[4], m_tb[4], m_sb[4], m_ab[4], m_thr[4], m_dflt[4];
    logic [5:0]  m_db[4];

    logic [7:0] q_st[$];
    logic       q_acc[$];
    int         q_cyc[$];
    string      q_tag[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [9:0] addr, input logic [31:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = data;
        case (sel)
            W_CODE:  m_code[addr[7:0]] = data;
            W_TOP:   m_top[addr[7:0]] = data[23:0];
            W_BANK:  m_bank[addr[9:8]][addr[7:0]] = data[12:0];
            W_DENSE: m_dense[addr] = data[7:0];
            W_ACC:   m_acc[addr[7:0]] = data[0];
            W_CFG: case (addr[4:2])
                3'd0: m_cb[addr[1:0]] = data[7:0];
                3'd1: m_tb[addr[1:0]] = data[7:0];
                3'd2: m_sb[addr[1:0]] = data[7:0];
                3'd3: m_db[addr[1:0]] = data[5:0];
                3'd4: m_ab[addr[1:0]] = data[7:0];
                3'd5: m_thr[addr[1:0]] = data[7:0];
                3'd6: m_dflt[addr[1:0]] = data[7:0];
                default: ;
            endcase
            default: ;
        endcase
    endtask

    task automatic cfg(input logic [1:0] d, input logic [2:0] fld, input logic [7:0] v);
        wr(W_CFG, {5'd0, fld, d}, {24'd0, v});
    endtask

    function automatic void predict(input logic [1:0] d, input logic [7:0] s, input logic [3:0] c,
                                    output logic [7:0] nx, output logic ac);
        logic [7:0] r;
        logic [7:0] off;
        logic [5:0] drow;
        logic [1:0] code;
        r = m_cb[d] + s;
        code = m_code[r][2*c +: 2];
        if (code != 2'b11) begin
            r = m_tb[d] + s;
            nx = m_top[r][8*code +: 8];
        end else if (s < m_thr[d]) begin
            r = m_sb[d] + s;
            nx = m_dflt[d];
            for (int k = 3; k >= 0; k--) begin
                if (m_bank[k][r][12] && (m_bank[k][r][11:8] == c)) nx = m_bank[k][r][7:0];
            end
        end else begin
            off = s - m_thr[d];
            drow = m_db[d] + off[5:0];
            nx = m_dense[{drow, c}];
        end
        r = m_ab[d] + nx;
        ac = m_acc[r];
    endfunction

    task automatic look(input logic [1:0] d, input logic [7:0] s, input logic [3:0] c,
                        input string tag);
        logic [7:0] nx;
        logic ac;
        @(posedge clk); #1;
        in_valid = 1'b1; in_dfa = d; in_state = s; in_class = c;
        predict(d, s, c, nx, ac);
        q_st.push_back(nx); q_acc.push_back(ac); q_cyc.push_back(cyc); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; wr_en = 1'b0;
        end
    endtask

    // Scoreboard monitor, sampling between edges.
    always @(negedge clk) begin
        if (rst_n && started) begin
            if (out_valid) begin
                if (q_st.size() == 0) begin
                    chk(1'b0, "R1 unexpected result", 1, 0);
                end else begin
                    chk(out_state == q_st[0], q_tag[0], out_state, q_st[0]);
                    chk(out_accept == q_acc[0], "R8 accept flag", out_accept, q_acc[0]);
                    chk(cyc == q_cyc[0] + 3, "R1 latency", cyc - q_cyc[0], 3);
                    void'(q_st.pop_front()); void'(q_acc.pop_front());
                    void'(q_cyc.pop_front()); void'(q_tag.pop_front());
                end
                last_st = out_state; last_acc = out_accept; have_last = 1'b1;
            end else if (have_last) begin
                chk(out_state == last_st, "R10 state hold", out_state, last_st);
                chk(out_accept == last_acc, "R10 accept hold", out_accept, last_acc);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] cr;
        for (int d = 0; d < 4; d++) begin
            m_cb[d] = '0; m_tb[d] = '0; m_sb[d] = '0; m_db[d] = '0;
            m_ab[d] = '0; m_thr[d] = '0; m_dflt[d] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
        chk(out_state == 8'd0, "R9 reset state", out_state, 0);
        chk(out_accept == 1'b0, "R9 reset accept", out_accept, 0);
        rst_n = 1'b1;

        for (int r = 0; r < 256; r++) begin
            wr(W_CODE, 10'(r), 32'd0); wr(W_TOP, 10'(r), 32'd0); wr(W_ACC, 10'(r), 32'd0);
        end
        for (int a = 0; a < 1024; a++) begin
            wr(W_BANK, 10'(a), 32'd0); wr(W_DENSE, 10'(a), 32'd0);
        end

        // Automaton 0: all bases zero (R9 leaves them so), threshold 16, default 5.
        cfg(2'd0, 3'd5, 8'd16); cfg(2'd0, 3'd6, 8'd5);
        // Automaton 1: shifted bases in every table (R7, R11).
        cfg(2'd1, 3'd0, 8'd100); cfg(2'd1, 3'd1, 8'd100); cfg(2'd1, 3'd2, 8'd100);
        cfg(2'd1, 3'd3, 8'd20);  cfg(2'd1, 3'd4, 8'd128); cfg(2'd1, 3'd5, 8'd16);
        cfg(2'd1, 3'd6, 8'd9);

        cr = '1; cr[1:0] = 2'b00; cr[3:2] = 2'b01; cr[5:4] = 2'b10;
        wr(W_CODE, 10'd2, cr);
        wr(W_TOP, 10'd2, {8'd0, 8'd30, 8'd20, 8'd10});
        wr(W_BANK, {2'd0, 8'd2}, {19'd0, 1'b1, 4'd3, 8'd40});
        wr(W_BANK, {2'd1, 8'd2}, {19'd0, 1'b1, 4'd4, 8'd41});
        wr(W_BANK, {2'd2, 8'd2}, {19'd0, 1'b0, 4'd5, 8'd42});
        wr(W_BANK, {2'd3, 8'd2}, {19'd0, 1'b1, 4'd4, 8'd43});
        wr(W_CODE, 10'd15, 32'hFFFF_FFFF);
        wr(W_BANK, {2'd0, 8'd15}, {19'd0, 1'b1, 4'd1, 8'd70});
        wr(W_CODE, 10'd16, 32'hFFFF_FFFF);
        wr(W_DENSE, 10'd1, 32'd71);
        cr = '1; cr[1:0] = 2'b01;
        wr(W_CODE, 10'd20, cr);
        wr(W_TOP, 10'd20, {8'd0, 8'd0, 8'd50, 8'd0});
        wr(W_DENSE, 10'd73, 32'd60);
        wr(W_DENSE, 10'd74, 32'd61);
        wr(W_ACC, 10'd20, 32'd1);
        wr(W_ACC, 10'd40, 32'd1);

        cr = '1; cr[1:0] = 2'b00;
        wr(W_CODE, 10'd102, cr);
        wr(W_TOP, 10'd102, {8'd0, 8'd0, 8'd0, 8'd90});
        wr(W_BANK, {2'd0, 8'd102}, {19'd0, 1'b1, 4'd3, 8'd91});
        wr(W_CODE, 10'd120, 32'hFFFF_FFFF);
        wr(W_DENSE, 10'd393, 32'd92);
        wr(W_ACC, 10'd218, 32'd1);
        idle(2);
        started = 1'b1;

        // Back-to-back burst (R1).
        look(2'd0, 8'd2, 4'd0, "R2 code 0 first field");
        look(2'd0, 8'd2, 4'd1, "R2 code 1 second field");
        look(2'd0, 8'd2, 4'd2, "R2 code 2 third field");
        look(2'd0, 8'd2, 4'd3, "R3 bank 0 tag match");
        look(2'd0, 8'd2, 4'd4, "R5 lowest bank wins");
        look(2'd0, 8'd2, 4'd5, "R4 invalid entry ignored");
        look(2'd0, 8'd2, 4'd7, "R4 no match default");
        look(2'd0, 8'd20, 4'd9, "R6 dense row entry");
        look(2'd0, 8'd20, 4'd10, "R6 dense neighbour class");
        look(2'd0, 8'd20, 4'd0, "R2 code on dense state");
        look(2'd0, 8'd15, 4'd1, "R6 below threshold uses banks");
        look(2'd0, 8'd16, 4'd1, "R6 at threshold uses dense");
        look(2'd0, 8'd15, 4'd2, "R4 boundary state default");
        idle(6);

        // Spaced lookups on the second automaton (R7).
        look(2'd1, 8'd2, 4'd0, "R7 shifted code and successor rows");
        idle(2);
        look(2'd1, 8'd2, 4'd3, "R7 shifted bank row");
        idle(1);
        look(2'd1, 8'd20, 4'd9, "R7 shifted dense row");
        look(2'd1, 8'd2, 4'd7, "R7 own default state");
        look(2'd0, 8'd2, 4'd0, "R7 same inputs other automaton");
        idle(6);

        // Rewrite a bank entry between lookups (R3, R11).
        wr(W_BANK, {2'd2, 8'd2}, {19'd0, 1'b1, 4'd5, 8'd44});
        idle(1);
        look(2'd0, 8'd2, 4'd5, "R3 newly valid bank 2 entry");
        idle(6);

        chk(q_st.size() == 0, "R1 all results returned", q_st.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule